// File: doc/BRIEF.md
# DRAM Bank State Legality Monitor

This block follows the command stream sent to a low-power DRAM device with eight banks and a self-refresh mode. It keeps a shadow copy of the device state: one open or closed bit per bank and one flag for self-refresh. When a command is presented, the block decides whether the command is allowed in that state. An allowed command updates the shadow state. A command that is not allowed leaves the state alone and is reported.

It sits beside a memory controller's command path as a synthesizable protocol guard. The `cmd_ok` output drops for one cycle after each rejected command. The `err_seen` output keeps a record of any rejection until reset. Timing parameters, addresses, data and refresh scheduling are outside this block.

Top module: `dram_bank_guard`

## Requirements
- R1: After reset all eight banks are closed, self-refresh is clear, `cmd_ok` is 1 and `err_seen` is 0.
- R2: Command codes are 0 close-all, 1 enter self-refresh, 2 leave self-refresh and 3 refresh-all. A per-bank code is 4+8*k+b, where b is the bank and k is 0 open, 1 write, 2 write-and-close, 3 read, 4 read-and-close, 5 close and 6 bank refresh.
- R3: While self-refresh is set, only codes 1 and 2 are allowed.
- R4: Outside self-refresh, code 2 is rejected.
- R5: Code 1 is rejected while any bank is open.
- R6: For a closed bank, only open and bank refresh are allowed.
- R7: For an open bank, open and bank refresh are rejected, and write, write-and-close, read, read-and-close and close are allowed.
- R8: An allowed open sets the bank's bit. An allowed write-and-close, read-and-close or close clears it. Write, read and bank refresh leave it unchanged.
- R9: After any allowed global command (codes 0 to 3), all bank bits are 0.
- R10: The self-refresh flag is set after an allowed code 1 and cleared after any other allowed command.
- R11: A rejected command changes no state. `cmd_ok` is 0 in the cycle after it and 1 after any cycle that has no rejection.
- R12: `err_seen` becomes 1 in the cycle after the first rejection and stays 1 until reset.
- R13: Codes 60 to 63 are always rejected.
- R14: A cycle with `cmd_vld` low changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | A command is presented this cycle |
| cmd_code | input | 6 | Command code (see R2) |
| cmd_ok | output | 1 | 0 for one cycle after a rejected command |
| err_seen | output | 1 | Sticky rejection flag |
| bank_open | output | 8 | Per-bank open bits |
| in_selfref | output | 1 | Self-refresh flag |

## Verification
The embedded properties check the following on every cycle: rejection of everything except codes 1 and 2 during self-refresh, rejection of code 2 outside self-refresh, rejection of code 1 while any bank is open, rejection of codes 60 to 63, stability of the state after a rejected or idle cycle, the sticky error flag, and closed banks during self-refresh. Only the bench's scenarios can show the exact per-bank update for each command kind and the clearing of the error flag by reset. The bench compares against a behavioural model on every clock while it drives directed sequences and a long stream of mostly legal commands.

// File: rtl/dram_bank_guard.sv
module dram_bank_guard #(
  parameter int NBANK = 8,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic [CODE_W-1:0] cmd_code,
  output logic              cmd_ok,
  output logic              err_seen,
  output logic [NBANK-1:0]  bank_open,
  output logic              in_selfref
);
  localparam int BW = $clog2(NBANK);
  localparam int NGLOB = 4;
  localparam int NKIND = 7;
  localparam int LAST_CODE = NGLOB + NKIND*NBANK - 1;

  localparam logic [2:0] K_ACT = 3'd0, K_WR = 3'd1, K_WRA = 3'd2,
                         K_RD = 3'd3, K_RDA = 3'd4, K_PRE = 3'd5, K_REF = 3'd6;

  logic          is_glob, in_range;
  logic [CODE_W-1:0] rel;
  logic [2:0]    kind;
  logic [BW-1:0] bnk;
  logic          tgt_open, any_open, legal;
  logic [NBANK-1:0] bank_nx;

  assign is_glob  = cmd_code < CODE_W'(NGLOB);
  assign in_range = cmd_code <= CODE_W'(LAST_CODE);
  assign rel      = cmd_code - CODE_W'(NGLOB);
  assign kind     = 3'(rel / CODE_W'(NBANK));
  assign bnk      = BW'(rel % CODE_W'(NBANK));
  assign tgt_open = bank_open[bnk];
  assign any_open = |bank_open;

  always_comb begin
    legal = 1'b0;
    if (in_selfref)
      legal = (cmd_code == CODE_W'(1)) || (cmd_code == CODE_W'(2));
    else if (is_glob)
      case (cmd_code[1:0])
        2'd1:    legal = !any_open;
        2'd2:    legal = 1'b0;
        default: legal = 1'b1;
      endcase
    else if (in_range)
      legal = tgt_open ? (kind != K_ACT && kind != K_REF)
                       : (kind == K_ACT || kind == K_REF);
  end

  always_comb begin
    bank_nx = bank_open;
    if (is_glob)
      bank_nx = '0;
    else if (kind == K_ACT)
      bank_nx[bnk] = 1'b1;
    else if (kind == K_WRA || kind == K_RDA || kind == K_PRE)
      bank_nx[bnk] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_open  <= '0;
      in_selfref <= 1'b0;
      cmd_ok     <= 1'b1;
      err_seen   <= 1'b0;
    end else begin
      cmd_ok <= !(cmd_vld && !legal);
      if (cmd_vld && !legal)
        err_seen <= 1'b1;
      if (cmd_vld && legal) begin
        bank_open  <= bank_nx;
        in_selfref <= (cmd_code == CODE_W'(1));
      end
    end
  end

  // R3
  selfref_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && in_selfref && cmd_code != CODE_W'(1) && cmd_code != CODE_W'(2) |=> !cmd_ok);
  // R4
  srx_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && !in_selfref && cmd_code == CODE_W'(2) |=> !cmd_ok);
  // R5
  sre_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && any_open && cmd_code == CODE_W'(1) |=> !cmd_ok);
  // R13
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && cmd_code > CODE_W'(LAST_CODE) |=> !cmd_ok);
  // R11
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ok |-> $stable(bank_open) && $stable(in_selfref));
  // R14
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> $stable(bank_open) && $stable(in_selfref) && cmd_ok);
  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_seen |=> err_seen);
  // R12
  err_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ok |-> err_seen);
  // R9
  selfref_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_selfref |-> bank_open == '0);
endmodule

// File: tb/tb_dram_bank_guard.sv
module tb_dram_bank_guard;
  logic clk = 0, rst_n = 0, cmd_vld = 0;
  logic [5:0] cmd_code = 0;
  logic cmd_ok, err_seen, in_selfref;
  logic [7:0] bank_open;

  always #2.5 clk = ~clk;

  dram_bank_guard dut (.clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_code(cmd_code),
    .cmd_ok(cmd_ok), .err_seen(err_seen), .bank_open(bank_open), .in_selfref(in_selfref));

  int total = 0, bad = 0;
  int m_bank[8];
  int m_sr, m_ok, m_err;
  bit done = 0;

  task automatic check(input bit cond, input string req, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int m_any();
    int s = 0;
    foreach (m_bank[i]) s += m_bank[i];
    return s;
  endfunction

  function automatic int m_mask();
    int v = 0;
    foreach (m_bank[i]) if (m_bank[i] != 0) v += (1 << i);
    return v;
  endfunction

  function automatic bit m_legal(input int c);
    int k, b;
    if (c > 59) return 0;
    if (m_sr != 0) return (c == 1 || c == 2);
    if (c == 2) return 0;
    if (c == 1) return m_any() == 0;
    if (c == 0 || c == 3) return 1;
    k = (c - 4) / 8; b = (c - 4) % 8;
    if (m_bank[b] != 0) return !(k == 0 || k == 6);
    return (k == 0 || k == 6);
  endfunction

  task automatic m_reset();
    foreach (m_bank[i]) m_bank[i] = 0;
    m_sr = 0; m_ok = 1; m_err = 0;
  endtask

  task automatic m_apply(input bit v, input int c);
    int k, b;
    m_ok = 1;
    if (!v) return;
    if (!m_legal(c)) begin m_ok = 0; m_err = 1; return; end
    if (c < 4) foreach (m_bank[i]) m_bank[i] = 0;
    else begin
      k = (c - 4) / 8; b = (c - 4) % 8;
      if (k == 0) m_bank[b] = 1;
      else if (k == 2 || k == 4 || k == 5) m_bank[b] = 0;
    end
    m_sr = (c == 1) ? 1 : 0;
  endtask

  task automatic compare();
    check(bank_open == 8'(m_mask()), "R8 bank bits", bank_open, m_mask());
    check(in_selfref == m_sr[0], "R10 self-refresh", in_selfref, m_sr);
    check(cmd_ok == m_ok[0], "R11 cmd_ok", cmd_ok, m_ok);
    check(err_seen == m_err[0], "R12 err_seen", err_seen, m_err);
  endtask

  task automatic issue(input bit v, input int c);
    cmd_vld = v; cmd_code = 6'(c);
    m_apply(v, c);
    @(posedge clk); @(negedge clk);
    cmd_vld = 0;
    compare();
  endtask

  task automatic do_reset();
    rst_n = 0; cmd_vld = 0;
    @(posedge clk); @(negedge clk);
    m_reset();
    rst_n = 1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c;
    @(negedge clk);
    do_reset();
    // R1
    check(bank_open == 0 && !in_selfref && cmd_ok && !err_seen, "R1 reset state",
          {bank_open, in_selfref, cmd_ok, err_seen}, 2);
    // R6: write to closed bank 3 rejected
    issue(1, 4 + 8*1 + 3);
    check(cmd_ok == 0, "R6 write to closed bank", cmd_ok, 0);
    issue(0, 0);
    check(cmd_ok == 1, "R11 cmd_ok back high", cmd_ok, 1);
    // R2/R8: open bank 5
    issue(1, 4 + 5);
    check(bank_open == 8'h20, "R2 open bank 5 code 9", bank_open, 8'h20);
    // R7: open again rejected
    issue(1, 4 + 5);
    check(cmd_ok == 0 && bank_open == 8'h20, "R7 reopen rejected", bank_open, 8'h20);
    issue(1, 4 + 8*6 + 5);
    check(cmd_ok == 0, "R7 bank refresh on open rejected", cmd_ok, 0);
    // R8: write/read keep open
    issue(1, 4 + 8*1 + 5); issue(1, 4 + 8*3 + 5);
    check(bank_open == 8'h20, "R8 write/read keep open", bank_open, 8'h20);
    // R5
    issue(1, 1);
    check(cmd_ok == 0 && !in_selfref, "R5 enter with bank open", cmd_ok, 0);
    // R8: read-and-close
    issue(1, 4 + 8*4 + 5);
    check(bank_open == 0, "R8 read-and-close", bank_open, 0);
    issue(1, 4 + 0); issue(1, 4 + 7);
    // R9
    issue(1, 0);
    check(bank_open == 0, "R9 close-all", bank_open, 0);
    issue(1, 4 + 2); issue(1, 3);
    check(bank_open == 0, "R9 refresh-all", bank_open, 0);
    // R4
    issue(1, 2);
    check(cmd_ok == 0, "R4 leave outside self-refresh", cmd_ok, 0);
    // R10 / R3
    issue(1, 1);
    check(in_selfref == 1, "R10 enter self-refresh", in_selfref, 1);
    issue(1, 4 + 1);
    check(cmd_ok == 0 && bank_open == 0, "R3 open in self-refresh", bank_open, 0);
    issue(1, 0);
    check(cmd_ok == 0, "R3 close-all in self-refresh", cmd_ok, 0);
    issue(1, 1);
    check(cmd_ok == 1 && in_selfref == 1, "R3 re-enter stays", in_selfref, 1);
    // R14
    issue(0, 2);
    check(in_selfref == 1, "R14 idle cycle", in_selfref, 1);
    issue(1, 2);
    check(in_selfref == 0, "R10 leave self-refresh", in_selfref, 0);
    // R13
    for (int i = 60; i < 64; i++) begin
      issue(1, i);
      check(cmd_ok == 0, "R13 out-of-range code", cmd_ok, 0);
    end
    // R12 stays, then reset clears
    check(err_seen == 1, "R12 sticky", err_seen, 1);
    do_reset();
    @(negedge clk);
    check(err_seen == 0, "R12 cleared by reset", err_seen, 0);
    // random stream, mostly legal
    for (int n = 0; n < 4000; n++) begin
      c = $urandom_range(0, 63);
      if ($urandom_range(0, 9) < 8)
        for (int t = 0; t < 20 && !m_legal(c); t++) c = $urandom_range(0, 59);
      issue($urandom_range(0, 7) != 0, c);
      if (n == 2000) do_reset();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule